// File: doc/BRIEF.md
# Passive Tamper Watch Controller

The block monitors a set of external tamper pins. Each pin first passes through a two-flop synchroniser. Each enabled channel then compares the pin against the level it is set to treat as active. When a channel sees its active level, it latches a sticky flag. Depending on the channel's settings, it may also raise an interrupt, emit a one-cycle erase request toward backup registers, and hold a lock that blocks reads of backup SRAM.

Software sets up the channels through a small word-indexed register set. Each channel has its own settings for:
- enable
- active level
- keep-storage (suppresses erase and lock)
- mute (suppresses interrupt, erase and lock, but not the flag)
- interrupt enable

Software reads the raw flags and clears them by writing ones. Two masked-status views exist, one for the secure side and one for the non-secure side. A guard bit decides which view is live and whether non-secure transactions may reach the registers at all.

Top module: `tamper_watch`

## Requirements
- R1: A channel whose enable bit (word 0) is 0 never sets its flag and never causes an interrupt, an erase pulse or a lock.
- R2: The channel's level bit (word 1) selects the active level: 0 means a low pin triggers, 1 means a high pin triggers. The flag (word 5) becomes 1 three rising edges after the pin reaches the active level (two synchroniser stages plus the flag register).
- R3: Flags are sticky. Writing to word 6 clears each flag whose written bit is 1 and leaves the other flags unchanged. A flag whose pin is still at its active level stays set despite the clear. Word 6 reads 0.
- R4: The masked status of a channel is flag AND interrupt-enable (word 4) AND NOT mute (word 3). It appears in the secure view (word 8) only when the guard bit is 1, and in the non-secure view (word 7) only when the guard bit is 0. The view that is not live reads 0.
- R5: irq_o is the OR of all bits of the live masked-status view.
- R6: erase_o is a single-cycle pulse, high in the cycle the flag of a channel first reads 1, when that channel's keep bit (word 2) and mute bit are both 0. A channel with keep set produces no pulse, and a level held longer produces no further pulse.
- R7: sram_lock_o is high while any flag is set on a channel whose keep and mute bits are both 0.
- R8: A muted channel still sets its flag, but drives neither the interrupt, the erase pulse, the lock nor its masked status.
- R9: The guard bit is word 9, bit 0. While it is 1, non-secure writes change nothing and non-secure reads return 0. Secure accesses always work.
- R10: After reset every register and flag is 0 and irq_o, erase_o and sram_lock_o are low.
- R11: A read returns its data in rsp_rdata_o one cycle after the request. Word indices 10 and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tamper_i | input | NCH | Asynchronous tamper pins |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_secure_i | input | 1 | Access comes from the secure side |
| req_addr_i | input | AW | Word index |
| req_wdata_i | input | DW | Write data |
| rsp_rdata_o | output | DW | Read data, one cycle after the request |
| irq_o | output | 1 | Tamper interrupt |
| erase_o | output | 1 | One-cycle backup-register erase request |
| sram_lock_o | output | 1 | Blocks backup SRAM reads |

## Verification
The hardest case to reach from the ports is a clear write that arrives while the pin still sits at its active level. The flag must survive the clear, and no second erase pulse may appear. The directed sequence holds the pin at its level across several cycles, issues the clear, and only then releases the pin and clears again. The random phase builds combinations of level, keep, mute and interrupt-enable in which many channels trigger on the same edge. It also toggles the guard bit, so that each configuration is read through both masked views and from both security sides.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int DW = 32;

    // word indices of the register set
    localparam int W_ENABLE = 0;
    localparam int W_LEVEL  = 1;
    localparam int W_KEEP   = 2;
    localparam int W_MUTE   = 3;
    localparam int W_IEN    = 4;
    localparam int W_FLAGS  = 5;
    localparam int W_CLEAR  = 6;
    localparam int W_NSVIEW = 7;
    localparam int W_SVIEW  = 8;
    localparam int W_GUARD  = 9;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= async_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/tw_match.sv
module tw_match #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] pin_i,
    input  logic [NCH-1:0] enable_i,
    input  logic [NCH-1:0] level_i,
    output logic [NCH-1:0] hit_o
);
    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            // active when the pin equals the selected level
            assign hit_o[c] = enable_i[c] & ~(pin_i[c] ^ level_i[c]);
        end
    endgenerate
endmodule

// File: rtl/tw_view.sv
module tw_view #(
    parameter int NCH = 4
) (
    input  logic [NCH-1:0] flag_i,
    input  logic [NCH-1:0] ien_i,
    input  logic [NCH-1:0] mute_i,
    input  logic [NCH-1:0] keep_i,
    input  logic           guard_i,
    output logic [NCH-1:0] ns_view_o,
    output logic [NCH-1:0] s_view_o,
    output logic           irq_o,
    output logic           lock_o
);
    logic [NCH-1:0] masked;

    always_comb begin
        masked    = flag_i & ien_i & ~mute_i;
        s_view_o  = guard_i ? masked : '0;
        ns_view_o = guard_i ? '0 : masked;
        irq_o     = |(s_view_o | ns_view_o);
        lock_o    = |(flag_i & ~keep_i & ~mute_i);
    end
endmodule

// File: rtl/tamper_watch.sv
module tamper_watch #(
    parameter int NCH = 4,
    parameter int AW  = 4,
    parameter int DW  = tw_pkg::DW
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] tamper_i,
    input  logic           req_valid_i,
    input  logic           req_write_i,
    input  logic           req_secure_i,
    input  logic [AW-1:0]  req_addr_i,
    input  logic [DW-1:0]  req_wdata_i,
    output logic [DW-1:0]  rsp_rdata_o,
    output logic           irq_o,
    output logic           erase_o,
    output logic           sram_lock_o
);
    import tw_pkg::*;

    typedef struct packed {
        logic [NCH-1:0] enable;
        logic [NCH-1:0] level;
        logic [NCH-1:0] keep;
        logic [NCH-1:0] mute;
        logic [NCH-1:0] ien;
        logic [NCH-1:0] flag;
        logic           guard;
        logic           erase;
        logic [DW-1:0]  rdata;
    } state_t;

    state_t s_d, s_q;

    logic [NCH-1:0] pin_sync;
    logic [NCH-1:0] hit;
    logic [NCH-1:0] ns_view, s_view;
    logic [NCH-1:0] clr_vec;
    logic [NCH-1:0] rise;
    logic           access_ok;
    logic           unused_wdata;

    tw_sync #(.WIDTH(NCH), .STAGES(2)) i_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(tamper_i),
        .sync_o (pin_sync)
    );

    tw_match #(.NCH(NCH)) i_match (
        .pin_i   (pin_sync),
        .enable_i(s_q.enable),
        .level_i (s_q.level),
        .hit_o   (hit)
    );

    tw_view #(.NCH(NCH)) i_view (
        .flag_i   (s_q.flag),
        .ien_i    (s_q.ien),
        .mute_i   (s_q.mute),
        .keep_i   (s_q.keep),
        .guard_i  (s_q.guard),
        .ns_view_o(ns_view),
        .s_view_o (s_view),
        .irq_o    (irq_o),
        .lock_o   (sram_lock_o)
    );

    always_comb begin
        s_d       = s_q;
        access_ok = req_valid_i & (req_secure_i | ~s_q.guard);
        clr_vec   = '0;

        if (access_ok && req_write_i) begin
            case (req_addr_i)
                AW'(W_ENABLE): s_d.enable = req_wdata_i[NCH-1:0];
                AW'(W_LEVEL):  s_d.level  = req_wdata_i[NCH-1:0];
                AW'(W_KEEP):   s_d.keep   = req_wdata_i[NCH-1:0];
                AW'(W_MUTE):   s_d.mute   = req_wdata_i[NCH-1:0];
                AW'(W_IEN):    s_d.ien    = req_wdata_i[NCH-1:0];
                AW'(W_CLEAR):  clr_vec    = req_wdata_i[NCH-1:0];
                AW'(W_GUARD):  s_d.guard  = req_wdata_i[0];
                default: ;
            endcase
        end

        // a persisting active level wins over a clear
        s_d.flag  = (s_q.flag & ~clr_vec) | hit;
        rise      = s_d.flag & ~s_q.flag;
        s_d.erase = |(rise & ~s_q.keep & ~s_q.mute);

        s_d.rdata = '0;
        if (access_ok && !req_write_i) begin
            case (req_addr_i)
                AW'(W_ENABLE): s_d.rdata[NCH-1:0] = s_q.enable;
                AW'(W_LEVEL):  s_d.rdata[NCH-1:0] = s_q.level;
                AW'(W_KEEP):   s_d.rdata[NCH-1:0] = s_q.keep;
                AW'(W_MUTE):   s_d.rdata[NCH-1:0] = s_q.mute;
                AW'(W_IEN):    s_d.rdata[NCH-1:0] = s_q.ien;
                AW'(W_FLAGS):  s_d.rdata[NCH-1:0] = s_q.flag;
                AW'(W_NSVIEW): s_d.rdata[NCH-1:0] = ns_view;
                AW'(W_SVIEW):  s_d.rdata[NCH-1:0] = s_view;
                AW'(W_GUARD):  s_d.rdata[0]       = s_q.guard;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rsp_rdata_o  = s_q.rdata;
    assign erase_o      = s_q.erase;
    assign unused_wdata = ^req_wdata_i[DW-1:NCH];
endmodule

// File: rtl/tw_checker.sv
module tw_checker #(
    parameter int NCH = 4
) (
    input logic           clk_i,
    input logic           rst_ni,
    input logic [NCH-1:0] enable_q,
    input logic [NCH-1:0] flag_q,
    input logic [NCH-1:0] clr_vec,
    input logic [NCH-1:0] ns_view,
    input logic [NCH-1:0] s_view,
    input logic [5*NCH:0] cfg_q,
    input logic           req_valid_i,
    input logic           req_write_i,
    input logic           req_secure_i,
    input logic           guard_q,
    input logic           erase_o
);
    // R1
    disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((flag_q & ~$past(flag_q) & ~$past(enable_q)) == '0));

    // R3
    flag_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((~flag_q & $past(flag_q) & ~$past(clr_vec)) == '0));

    // R4
    one_view_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !((|ns_view) && (|s_view)));

    // R6
    erase_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        erase_o |-> ((flag_q & ~$past(flag_q)) != '0));

    // R9
    guard_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && req_write_i && !req_secure_i && guard_q) |=> $stable(cfg_q));
endmodule

bind tamper_watch tw_checker #(.NCH(NCH)) i_tw_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_q    (s_q.enable),
    .flag_q      (s_q.flag),
    .clr_vec     (clr_vec),
    .ns_view     (ns_view),
    .s_view      (s_view),
    .cfg_q       ({s_q.enable, s_q.level, s_q.keep, s_q.mute, s_q.ien, s_q.guard}),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_secure_i(req_secure_i),
    .guard_q     (s_q.guard),
    .erase_o     (erase_o)
);

// File: tb/test_tamper_watch.sv
module test_tamper_watch;
    localparam int NCH = 4;
    localparam int AW  = 4;
    localparam int DW  = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NCH-1:0] tamper = '1;
    logic           req_valid = 1'b0, req_write = 1'b0, req_secure = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic [DW-1:0]  rdata;
    logic           irq, erase, lock;

    int checks = 0;
    int failures = 0;
    int erase_cnt = 0;
    logic [DW-1:0] rv;
    logic [NCH-1:0] all_ch = '1;

    always #4 clk = ~clk;

    tamper_watch #(.NCH(NCH), .AW(AW), .DW(DW)) i_tamper_watch (
        .clk_i(clk), .rst_ni(rst_n), .tamper_i(tamper),
        .req_valid_i(req_valid), .req_write_i(req_write), .req_secure_i(req_secure),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_rdata_o(rdata),
        .irq_o(irq), .erase_o(erase), .sram_lock_o(lock)
    );

    always @(negedge clk) if (erase) erase_cnt++;

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(int idx, logic [DW-1:0] d, logic sec);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_secure = sec;
        req_addr = AW'(idx); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(int idx, logic sec, output logic [DW-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_secure = sec; req_addr = AW'(idx);
        @(negedge clk);
        d = rdata;
        req_valid = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [NCH-1:0] exp_flags(logic [NCH-1:0] en, logic [NCH-1:0] lvl,
                                                 logic [NCH-1:0] pins);
        return en & ~(pins ^ lvl);
    endfunction

    function automatic logic [NCH-1:0] exp_masked(logic [NCH-1:0] fl, logic [NCH-1:0] ie,
                                                  logic [NCH-1:0] mu);
        return fl & ie & ~mu;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        void'($urandom(32'h5eed_7a11));
        wait_cyc(3);
        rst_n = 1'b1;

        // R10: reset state
        check("R10 irq", DW'(irq), 0);
        check("R10 erase", DW'(erase), 0);
        check("R10 lock", DW'(lock), 0);
        for (int w = 0; w < 10; w++) begin
            bus_rd(w, 1'b1, rv);
            check("R10 register", rv, 0);
        end

        // R2: low-level channel 0 with sync latency
        bus_wr(1, 0, 1'b1);
        bus_wr(4, 1, 1'b1);
        bus_wr(0, 1, 1'b1);
        erase_cnt = 0;
        @(negedge clk); tamper[0] = 1'b0;
        wait_cyc(2);
        check("R2 no flag before sync", DW'(irq), 0);
        wait_cyc(1);
        check("R2 low triggers / R5 irq", DW'(irq), 1);
        check("R7 lock", DW'(lock), 1);
        wait_cyc(8);
        check("R6 single erase pulse", erase_cnt, 1);
        bus_rd(7, 1'b0, rv);
        check("R4 non-secure view", rv, 1);

        // R3: clear while level persists
        bus_wr(6, 1, 1'b1);
        bus_rd(5, 1'b1, rv);
        check("R3 flag survives clear", rv, 1);
        check("R6 no repeat pulse", erase_cnt, 1);
        @(negedge clk); tamper[0] = 1'b1;
        wait_cyc(3);
        bus_wr(6, 1, 1'b1);
        bus_rd(5, 1'b1, rv);
        check("R3 flag cleared", rv, 0);
        check("R7 lock released", DW'(lock), 0);
        check("R5 irq released", DW'(irq), 0);
        bus_rd(6, 1'b1, rv);
        check("R3 clear reads zero", rv, 0);

        // R2/R6: high-level channel 1 with keep set
        bus_wr(1, 2, 1'b1);
        bus_wr(2, 2, 1'b1);
        bus_wr(0, 2, 1'b1);
        erase_cnt = 0;
        @(negedge clk); tamper[1] = 1'b1;
        wait_cyc(4);
        bus_rd(5, 1'b1, rv);
        check("R2 high triggers", rv, 2);
        check("R6 keep suppresses erase", erase_cnt, 0);
        check("R7 keep suppresses lock", DW'(lock), 0);

        // R8: muted channel 2
        bus_wr(0, 0, 1'b1);
        bus_wr(6, 32'hF, 1'b1);
        bus_wr(1, 0, 1'b1);
        bus_wr(2, 0, 1'b1);
        bus_wr(3, 4, 1'b1);
        bus_wr(4, 4, 1'b1);
        bus_wr(0, 4, 1'b1);
        erase_cnt = 0;
        @(negedge clk); tamper[2] = 1'b0;
        wait_cyc(4);
        bus_rd(5, 1'b1, rv);
        check("R8 muted flag set", rv, 4);
        check("R8 muted irq", DW'(irq), 0);
        check("R8 muted erase", erase_cnt, 0);
        check("R8 muted lock", DW'(lock), 0);
        bus_rd(7, 1'b1, rv);
        check("R8 muted status", rv, 0);

        // R1: channel 3 disabled at active level
        @(negedge clk); tamper[3] = 1'b0;
        wait_cyc(4);
        bus_rd(5, 1'b1, rv);
        check("R1 disabled channel", rv[3], 0);

        // R9/R4: guard
        bus_wr(3, 0, 1'b1);
        bus_wr(9, 1, 1'b1);
        bus_wr(0, 32'hF, 1'b0);
        bus_rd(0, 1'b1, rv);
        check("R9 non-secure write ignored", rv, 4);
        bus_rd(5, 1'b0, rv);
        check("R9 non-secure read zero", rv, 0);
        bus_rd(8, 1'b1, rv);
        check("R4 secure view live", rv, 4);
        bus_rd(7, 1'b1, rv);
        check("R4 non-secure view idle", rv, 0);
        check("R5 irq from secure view", DW'(irq), 1);

        // R11: unmapped word
        bus_wr(12, 32'hF, 1'b1);
        bus_rd(12, 1'b1, rv);
        check("R11 unmapped reads zero", rv, 0);
        bus_rd(0, 1'b1, rv);
        check("R11 unmapped write no effect", rv, 4);

        // random configurations
        for (int it = 0; it < 60; it++) begin
            logic [NCH-1:0] en, lvl, kp, mu, ie, pins, ef, em;
            logic gd;
            en = NCH'($urandom); lvl = NCH'($urandom); kp = NCH'($urandom);
            mu = NCH'($urandom); ie = NCH'($urandom); pins = NCH'($urandom);
            gd = 1'($urandom);
            bus_wr(0, 0, 1'b1);
            bus_wr(6, DW'(all_ch), 1'b1);
            bus_rd(5, 1'b1, rv);
            check("R3 random clear", rv, 0);
            bus_wr(1, DW'(lvl), 1'b1);
            bus_wr(2, DW'(kp), 1'b1);
            bus_wr(3, DW'(mu), 1'b1);
            bus_wr(4, DW'(ie), 1'b1);
            bus_wr(9, DW'(gd), 1'b1);
            @(negedge clk); tamper = pins;
            wait_cyc(3);
            erase_cnt = 0;
            bus_wr(0, DW'(en), 1'b1);
            wait_cyc(2);
            ef = exp_flags(en, lvl, pins);
            em = exp_masked(ef, ie, mu);
            bus_rd(5, 1'b1, rv);
            check("R2 random flags", rv, DW'(ef));
            bus_rd(8, 1'b1, rv);
            check("R4 random secure view", rv, gd ? DW'(em) : 0);
            bus_rd(7, 1'b1, rv);
            check("R4 random non-secure view", rv, gd ? 0 : DW'(em));
            bus_rd(5, 1'b0, rv);
            check("R9 random non-secure read", rv, gd ? 0 : DW'(ef));
            check("R5 random irq", DW'(irq), DW'(|em));
            check("R7 random lock", DW'(lock), DW'(|(ef & ~kp & ~mu)));
            check("R6 random erase", erase_cnt, (|(ef & ~kp & ~mu)) ? 1 : 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule